// File: doc/BRIEF.md
# Instruction Fetch Permission Checker

This block sits after address translation on the instruction fetch path and judges each fetch against the attributes of the page it hit. Two faults are possible. The first is an execute-permission fault: the page does not grant execute rights to the current privilege level. The second is a byte-ordering fault. It is raised when the page asks for a byte order the core cannot fetch in, or when a fetch steps across a page boundary into a page of a different byte order than the page before it.

The result is a registered verdict one cycle after the fetch strobe. It carries a valid flag, a cause code, the byte-order bit destined for the exception syndrome register, and a suppress signal that kills the faulting instruction. A pending exception of higher priority masks the verdict completely. Page lookup and interrupt vectoring belong to neighbouring blocks.

Top module: `ifetch_perm_chk`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `exc_vld`, `exc_cause`, `esr_bo` and `suppress` are all 0.
- R2: A fetch in user mode (`priv_sup`=0) from a page with `pg_ux`=0 gives `exc_vld`=1 and `exc_cause`=2'b01 (execute permission) on the next cycle.
- R3: A fetch in supervisor mode (`priv_sup`=1) from a page with `pg_sx`=0 gives `exc_vld`=1 and `exc_cause`=2'b01 on the next cycle. The execute bit of the other privilege level has no effect.
- R4: A fetch whose page order `pg_endian` selects a 0 bit in `order_cap` gives `exc_vld`=1 and `exc_cause`=2'b10 (byte ordering) on the next cycle. Bit i of `order_cap` set means order code i is supported; code 0 is big-endian and code 1 is little-endian.
- R5: A fetch with `crossed_page`=1 and `prev_endian` different from `pg_endian` raises the byte-ordering cause 2'b10. Crossing into a page of the same order raises nothing, and a change of order without a crossing raises nothing.
- R6: When an execute-permission fault and a byte-ordering fault hold in the same fetch, the cause is 2'b01.
- R7: `esr_bo` is 1 exactly when `exc_vld`=1 and `exc_cause`=2'b10; otherwise it is 0.
- R8: `suppress` equals `exc_vld` in every cycle.
- R9: A fetch presented with `hi_pri_pend`=1 produces no exception: all outputs are 0 on the next cycle.
- R10: Outputs reflect the fetch one cycle later. A cycle with `fetch_vld`=0 gives all outputs 0 on the next cycle, and `exc_cause` is 2'b00 whenever `exc_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | A translated fetch is presented this cycle |
| priv_sup | input | 1 | 1 = supervisor mode, 0 = user mode |
| pg_ux | input | 1 | Page grants execute to user mode |
| pg_sx | input | 1 | Page grants execute to supervisor mode |
| pg_endian | input | ENDIAN_W | Byte order code of the fetched page |
| prev_endian | input | ENDIAN_W | Byte order code of the previous fetch's page |
| crossed_page | input | 1 | This fetch entered a new page relative to the previous fetch |
| order_cap | input | 2**ENDIAN_W | Bit per order code, 1 = order supported |
| hi_pri_pend | input | 1 | A higher-priority exception is pending |
| exc_vld | output | 1 | Instruction storage exception raised |
| exc_cause | output | 2 | 00 none, 01 execute permission, 10 byte ordering |
| esr_bo | output | 1 | Syndrome byte-order bit |
| suppress | output | 1 | Kill the faulting instruction |

## Verification
The hardest case to reach from the ports is a fetch that holds both fault kinds while no higher-priority exception is pending. It needs a missing execute right for the active privilege level, and at the same time either an unsupported order or a crossing into a page of the other order. The bench sweeps every combination of the ten single-bit inputs in the one-bit order configuration. That sweep covers every overlap of the two fault sources with the mask, the crossing flag and each capability pattern, and it checks the full output set one cycle after each fetch. Back-to-back idle cycles and a reset applied in the middle of the run confirm that no verdict lingers.

// File: rtl/ifpc_pkg.sv
package ifpc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_EXEC  = 2'b01,
    CAUSE_ORDER = 2'b10
  } ifpc_cause_e;
endpackage

// File: rtl/ifpc_perm_eval.sv
module ifpc_perm_eval (
  input  logic priv_sup,
  input  logic pg_ux,
  input  logic pg_sx,
  output logic exec_flt
);
  // the execute right of the active privilege level decides
  always_comb begin
    exec_flt = priv_sup ? ~pg_sx : ~pg_ux;
  end
endmodule

// File: rtl/ifpc_order_eval.sv
module ifpc_order_eval #(
  parameter int ENDIAN_W = 1,
  localparam int ORDERS = 2 ** ENDIAN_W
) (
  input  logic [ENDIAN_W-1:0] pg_endian,
  input  logic [ENDIAN_W-1:0] prev_endian,
  input  logic                crossed_page,
  input  logic [ORDERS-1:0]   order_cap,
  output logic                order_flt
);
  logic unsupported;
  logic switched;

  always_comb begin
    unsupported = ~order_cap[pg_endian];
    switched    = crossed_page && (prev_endian != pg_endian);
    order_flt   = unsupported | switched;
  end
endmodule

// File: rtl/ifpc_out_reg.sv
module ifpc_out_reg
  import ifpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        fetch_vld,
  input  logic        hi_pri_pend,
  input  logic        exec_flt,
  input  logic        order_flt,
  output logic        exc_vld,
  output logic [1:0]  exc_cause,
  output logic        esr_bo,
  output logic        suppress
);
  logic        take;
  ifpc_cause_e cause_d;

  always_comb begin
    take = fetch_vld && !hi_pri_pend && (exec_flt || order_flt);
    if (!take)        cause_d = CAUSE_NONE;
    else if (exec_flt) cause_d = CAUSE_EXEC;
    else              cause_d = CAUSE_ORDER;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_vld   <= 1'b0;
      exc_cause <= CAUSE_NONE;
      esr_bo    <= 1'b0;
      suppress  <= 1'b0;
    end else begin
      exc_vld   <= take;
      exc_cause <= cause_d;
      esr_bo    <= (cause_d == CAUSE_ORDER);
      suppress  <= take;
    end
  end
endmodule

// File: rtl/ifetch_perm_chk.sv
module ifetch_perm_chk #(
  parameter int ENDIAN_W = 1,
  localparam int ORDERS = 2 ** ENDIAN_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fetch_vld,
  input  logic                priv_sup,
  input  logic                pg_ux,
  input  logic                pg_sx,
  input  logic [ENDIAN_W-1:0] pg_endian,
  input  logic [ENDIAN_W-1:0] prev_endian,
  input  logic                crossed_page,
  input  logic [ORDERS-1:0]   order_cap,
  input  logic                hi_pri_pend,
  output logic                exc_vld,
  output logic [1:0]          exc_cause,
  output logic                esr_bo,
  output logic                suppress
);
  logic exec_flt;
  logic order_flt;

  ifpc_perm_eval perm_i (
    .priv_sup (priv_sup),
    .pg_ux    (pg_ux),
    .pg_sx    (pg_sx),
    .exec_flt (exec_flt)
  );

  ifpc_order_eval #(.ENDIAN_W(ENDIAN_W)) order_i (
    .pg_endian    (pg_endian),
    .prev_endian  (prev_endian),
    .crossed_page (crossed_page),
    .order_cap    (order_cap),
    .order_flt    (order_flt)
  );

  ifpc_out_reg out_i (
    .clk         (clk),
    .rst         (rst),
    .fetch_vld   (fetch_vld),
    .hi_pri_pend (hi_pri_pend),
    .exec_flt    (exec_flt),
    .order_flt   (order_flt),
    .exc_vld     (exc_vld),
    .exc_cause   (exc_cause),
    .esr_bo      (esr_bo),
    .suppress    (suppress)
  );
endmodule

// File: rtl/ifetch_perm_chk_sva.sv
module ifetch_perm_chk_sva #(
  parameter int ENDIAN_W = 1,
  localparam int ORDERS = 2 ** ENDIAN_W
) (
  input logic                clk,
  input logic                rst,
  input logic                fetch_vld,
  input logic                priv_sup,
  input logic                pg_ux,
  input logic                pg_sx,
  input logic [ENDIAN_W-1:0] pg_endian,
  input logic [ENDIAN_W-1:0] prev_endian,
  input logic                crossed_page,
  input logic [ORDERS-1:0]   order_cap,
  input logic                hi_pri_pend,
  input logic                exc_vld,
  input logic [1:0]          exc_cause,
  input logic                esr_bo,
  input logic                suppress
);
  a_r2_user_exec: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && !hi_pri_pend && !priv_sup && !pg_ux) |=> (exc_vld && exc_cause == 2'b01));

  a_r3_sup_exec: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && !hi_pri_pend && priv_sup && !pg_sx) |=> (exc_vld && exc_cause == 2'b01));

  a_r5_switch_order: assert property (@(posedge clk) disable iff (rst)
    (fetch_vld && !hi_pri_pend && crossed_page && (prev_endian != pg_endian)
     && (priv_sup ? pg_sx : pg_ux)) |=> (exc_vld && exc_cause == 2'b10));

  a_r7_bo_matches_cause: assert property (@(posedge clk) disable iff (rst)
    esr_bo == (exc_vld && exc_cause == 2'b10));

  a_r8_suppress_tracks: assert property (@(posedge clk) disable iff (rst)
    suppress == exc_vld);

  a_r9_masked: assert property (@(posedge clk) disable iff (rst)
    hi_pri_pend |=> !exc_vld);

  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !fetch_vld |=> (!exc_vld && exc_cause == 2'b00));
endmodule

bind ifetch_perm_chk ifetch_perm_chk_sva #(.ENDIAN_W(ENDIAN_W)) sva_i (.*);

// File: tb/ifetch_perm_chk_tb_top.sv
module ifetch_perm_chk_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fetch_vld = 1'b0, priv_sup = 1'b0, pg_ux = 1'b0, pg_sx = 1'b0;
  logic [0:0] pg_endian = '0, prev_endian = '0;
  logic       crossed_page = 1'b0, hi_pri_pend = 1'b0;
  logic [1:0] order_cap = 2'b11;
  logic       exc_vld, esr_bo, suppress;
  logic [1:0] exc_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ifetch_perm_chk #(.ENDIAN_W(1)) dut_i (.*);

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s vld/cause/bo/sup act=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {exc_vld, exc_cause, esr_bo, suppress};
  endfunction

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 5'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", outs(), 5'b0);

    for (int v = 0; v < 1024; v++) begin
      logic ex, bo, tk;
      logic [1:0] cz;
      string tag;
      {fetch_vld, priv_sup, pg_ux, pg_sx, pg_endian, prev_endian,
       crossed_page, order_cap, hi_pri_pend} = v[9:0];
      ex = priv_sup ? !pg_sx : !pg_ux;
      bo = (order_cap[pg_endian] == 1'b0) || (crossed_page && prev_endian != pg_endian);
      tk = fetch_vld && !hi_pri_pend && (ex || bo);
      cz = !tk ? 2'd0 : (ex ? 2'd1 : 2'd2);
      if (!fetch_vld) tag = "R10 idle";
      else if (hi_pri_pend) tag = "R9 masked";
      else if (ex && bo) tag = "R6 precedence";
      else if (ex) tag = priv_sup ? "R3 sup exec" : "R2 user exec";
      else if (!order_cap[pg_endian]) tag = "R4 unsupported order";
      else tag = "R5 crossing R7 R8";
      @(negedge clk);
      check(tag, outs(), {tk, cz, cz == 2'd2, tk});
    end

    // idle right after a fault
    fetch_vld = 1'b1; hi_pri_pend = 1'b0; priv_sup = 1'b0; pg_ux = 1'b0;
    @(negedge clk);
    check("R2 directed", outs(), 5'b1_01_0_1);
    fetch_vld = 1'b0;
    @(negedge clk);
    check("R10 clears", outs(), 5'b0);
    // reset mid-run with a faulting fetch present
    fetch_vld = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", outs(), 5'b0);
    rst = 1'b0; fetch_vld = 1'b0;
    @(negedge clk);
    check("R1 post reset idle", outs(), 5'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule